// File: doc/BRIEF.md
# Command-Driven I2C Master Sequencer

This block is a single-master I2C engine for 7-bit addressing. Software, or a controlling state machine, drives it through one-cycle command pulses. There are five commands: start, repeated start, stop, receive one byte, and send an acknowledge bit. Each accepted command raises its own pending bit. That bit drops by itself once the bus condition or transfer it asked for is finished. A write to the data buffer while the bus is held and the sequencer is idle sends that byte, most significant bit first, and captures the slave's answer on the ninth clock.

After every completed operation the block raises a sticky completion flag, which stays set until a clear pulse. A buffer write that arrives when the bus is not ready is dropped and raises a sticky collision flag. SDA and SCL are open-drain: the block only pulls a line low or releases it. Every bus bit is built from four quarter-phases. Each quarter lasts `reload + 1` system clocks, so a 100 kHz SCL needs a reload value to match the system clock.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both lines are released (`scl_oe`=0, `sda_oe`=0), and all pending bits, `done_flag`, `wcol`, `ack_status` and `bus_held` are 0.
- R2: A start command accepted while the bus is free pulls SDA low while SCL is high, then leaves both lines pulled low. It sets `bus_held`, clears `start_pend` and sets `done_flag`.
- R3: A repeated-start command accepted while the bus is held produces a new SDA fall while SCL is high, ends with both lines low, clears `rstart_pend` and sets `done_flag`.
- R4: A stop command accepted while the bus is held produces an SDA rise while SCL is high, ends with both lines released and `bus_held`=0, clears `stop_pend` and sets `done_flag`.
- R5: A buffer write accepted while the bus is held and no operation is running sends the 8 bits most significant first, one per SCL high pulse, then releases SDA for a ninth clock. `tx_busy` is 1 during this transfer.
- R6: The SDA level sampled during the ninth clock is stored in `ack_status`: 0 means acknowledged, 1 means not acknowledged. `ack_status` changes at no other time.
- R7: The receive command clocks 8 bits with SDA released and loads them, most significant first, into `buf_rdata`. It then clears `rxen_pend` and sets `done_flag`.
- R8: The acknowledge command drives `ack_value` for one SCL pulse (0 pulls SDA low, 1 releases it), then clears `ack_pend` and sets `done_flag`.
- R9: A buffer write made while the bus is free or an operation is running leaves `buf_rdata` unchanged, produces no SCL pulse and sets `wcol`. `wcol` stays set until a `wcol_clr` pulse.
- R10: Every SCL high pulse of a data or acknowledge bit lasts exactly 2 × (`reload` + 1) system clocks.
- R11: Inside data and acknowledge bits, SDA changes only while SCL is pulled low.
- R12: `done_flag` rises only when an operation completes, and a `done_clr` pulse returns it to 0.
- R13: A command that arrives while an operation is running, or that does not fit the bus state (start while held; any other command while free), is ignored and raises no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload | input | RLD_W | Quarter-phase length minus one, in system clocks |
| cmd_start | input | 1 | Start-condition command pulse |
| cmd_rstart | input | 1 | Repeated-start command pulse |
| cmd_stop | input | 1 | Stop-condition command pulse |
| cmd_rxen | input | 1 | Receive-one-byte command pulse |
| cmd_ack | input | 1 | Acknowledge-sequence command pulse |
| ack_value | input | 1 | Bit sent by the acknowledge sequence (0 ACK, 1 NACK) |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Byte written to the data buffer |
| done_clr | input | 1 | Clears the completion flag |
| wcol_clr | input | 1 | Clears the write-collision flag |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| start_pend | output | 1 | Start command in progress |
| rstart_pend | output | 1 | Repeated-start command in progress |
| stop_pend | output | 1 | Stop command in progress |
| rxen_pend | output | 1 | Receive command in progress |
| ack_pend | output | 1 | Acknowledge command in progress |
| buf_rdata | output | 8 | Data buffer: last written or received byte |
| done_flag | output | 1 | Sticky completion flag |
| ack_status | output | 1 | Slave answer to the last sent byte |
| wcol | output | 1 | Sticky write-collision flag |
| bus_held | output | 1 | Bus owned between start and stop |
| tx_busy | output | 1 | Byte transmission in progress |

## Verification
On every cycle the assertions check several rules:
- SDA never moves under a high SCL inside a data bit.
- Quarter ticks never come back to back when `reload` is non-zero.
- Start leaves both lines low and stop releases both.
- Rejected buffer writes always raise the collision flag.
- Commands are taken only by an idle sequencer, and the acknowledge status and completion flag change only at the end of an operation.

Other behaviour needs the bench's scenarios, run under each small reload value. A slave model on the bus shows the actual order of transmitted bits, the ACK and NACK capture, the received byte and the acknowledge value sent. The same scenarios measure the exact SCL high time, show that a write to a free bus makes no clock pulse, and confirm that commands given at the wrong moment are ignored.

// File: rtl/i2c_cmd_pkg.sv
// Package: shared encodings for the I2C command sequencer.
// Assumes an open-drain bus where 1 in a drive pair means "pull low".
package i2c_cmd_pkg;

    localparam int BYTE_W   = 8;
    localparam int CMD_N    = 5;
    localparam int CI_START = 0;
    localparam int CI_RSTRT = 1;
    localparam int CI_STOP  = 2;
    localparam int CI_RX    = 3;
    localparam int CI_ACK   = 4;

    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_RSTART = 2'd1,
        OP_STOP   = 2'd2,
        OP_BIT    = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_COND = 3'd1,
        SQ_TX   = 3'd2,
        SQ_RX   = 3'd3,
        SQ_ACK  = 3'd4
    } seq_e;

    // Line drive {scl_low, sda_low} for a bus operation in quarter q.
    function automatic logic [1:0] drive_f(input bus_op_e op, input logic [1:0] q,
                                           input logic b);
        logic [1:0] r;
        case (op)
            OP_START: begin
                case (q)
                    2'd0:    r = 2'b00;
                    2'd1:    r = 2'b01;
                    2'd2:    r = 2'b01;
                    default: r = 2'b11;
                endcase
            end
            OP_RSTART: begin
                case (q)
                    2'd0:    r = 2'b10;
                    2'd1:    r = 2'b00;
                    2'd2:    r = 2'b01;
                    default: r = 2'b11;
                endcase
            end
            OP_STOP: begin
                case (q)
                    2'd0:    r = 2'b11;
                    2'd1:    r = 2'b01;
                    default: r = 2'b00;
                endcase
            end
            default: begin
                r[0] = ~b;
                r[1] = (q == 2'd0) || (q == 2'd3);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2c_qtick.sv
// Module: quarter-phase tick generator.
// Emits one tick every (reload + 1) clocks while run is high; restarts
// from zero whenever run is low, so every operation starts on a full quarter.
// Assumes reload is held stable while run is high.
module i2c_qtick #(
    parameter int RLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [RLD_W-1:0] reload,
    output logic             tick
);

    logic [RLD_W-1:0] cnt;

    // Count clocks within the current quarter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == reload) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == reload);

    // R10
    quarter_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload != '0 && $stable(reload)) |=> !tick);

endmodule

// File: rtl/i2c_bit_engine.sv
// Module: bus-level operation engine.
// Runs one operation (start, repeated start, stop or one data bit) over
// four quarter-phases and drives the open-drain lines from a phase table.
// Between operations it holds the final line levels of the last one.
// Samples SDA at the end of the first SCL-high quarter of a data bit.
// Assumes go arrives only while the engine is inactive.
module i2c_bit_engine
    import i2c_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  bus_op_e op_in,
    input  logic    bit_in,
    input  logic    tick,
    input  logic    sda_in,
    output logic    active,
    output logic    done,
    output logic    rx_bit,
    output logic    scl_low,
    output logic    sda_low
);

    bus_op_e    op_q;
    logic       bit_q;
    logic [1:0] q;
    logic [1:0] hold;
    logic [1:0] drv;

    // Step through the four quarters of the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
            op_q   <= OP_START;
            bit_q  <= 1'b1;
            q      <= 2'd0;
            hold   <= 2'b00;
            rx_bit <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    op_q   <= op_in;
                    bit_q  <= bit_in;
                    q      <= 2'd0;
                end
            end else if (tick) begin
                if (q == 2'd1 && op_q == OP_BIT) begin
                    rx_bit <= sda_in;
                end
                if (q == 2'd3) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    hold   <= drive_f(op_q, 2'd3, bit_q);
                end else begin
                    q <= q + 2'd1;
                end
            end
        end
    end

    // Line drive: phase table while running, held levels otherwise.
    always_comb begin
        drv = active ? drive_f(op_q, q, bit_q) : hold;
    end

    assign scl_low = drv[1];
    assign sda_low = drv[0];

    // R11
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && op_q == OP_BIT && $past(op_q) == OP_BIT &&
         !scl_low && !$past(scl_low)) |-> $stable(sda_low));

    // R5
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active);

endmodule

// File: rtl/i2c_seq_ctrl.sv
// Module: command and byte sequencer.
// Accepts one command or buffer write while idle, keeps its pending bit,
// issues the bus operations it needs to the bit engine, and finishes by
// clearing the pending bit and raising the completion flag.
// Rejected buffer writes raise the collision flag.
// Assumes the bit engine answers every go with exactly one done pulse.
module i2c_seq_ctrl
    import i2c_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_rstart,
    input  logic              cmd_stop,
    input  logic              cmd_rxen,
    input  logic              cmd_ack,
    input  logic              ack_value,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              done_clr,
    input  logic              wcol_clr,
    input  logic              eng_done,
    input  logic              eng_rx_bit,
    output logic              eng_go,
    output bus_op_e           eng_op,
    output logic              eng_bit,
    output logic [CMD_N-1:0]  pend,
    output logic [BYTE_W-1:0] buf_rdata,
    output logic              done_flag,
    output logic              ack_status,
    output logic              wcol,
    output logic              owned,
    output logic              tx_busy
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);

    seq_e              seq;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              cmd_ok;
    logic              wr_take;

    // Decide whether a command or the buffer write is taken this cycle.
    always_comb begin
        cmd_ok  = (cmd_start && !owned) ||
                  ((cmd_rstart || cmd_stop || cmd_rxen || cmd_ack) && owned);
        wr_take = buf_wr && owned && (seq == SQ_IDLE) && !cmd_ok;
    end

    assign tx_busy = (seq == SQ_TX);

    // Command acceptance, byte sequencing and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq        <= SQ_IDLE;
            pend       <= '0;
            owned      <= 1'b0;
            shreg      <= '0;
            bitcnt     <= '0;
            eng_go     <= 1'b0;
            eng_op     <= OP_START;
            eng_bit    <= 1'b1;
            buf_rdata  <= '0;
            done_flag  <= 1'b0;
            ack_status <= 1'b0;
            wcol       <= 1'b0;
        end else begin
            eng_go <= 1'b0;
            if (done_clr) begin
                done_flag <= 1'b0;
            end
            if (wcol_clr) begin
                wcol <= 1'b0;
            end
            if (buf_wr && !wr_take) begin
                wcol <= 1'b1;
            end
            case (seq)
                SQ_IDLE: begin
                    if (cmd_start && !owned) begin
                        pend[CI_START] <= 1'b1;
                        seq     <= SQ_COND;
                        eng_go  <= 1'b1;
                        eng_op  <= OP_START;
                        eng_bit <= 1'b1;
                    end else if (owned) begin
                        if (cmd_rstart) begin
                            pend[CI_RSTRT] <= 1'b1;
                            seq     <= SQ_COND;
                            eng_go  <= 1'b1;
                            eng_op  <= OP_RSTART;
                            eng_bit <= 1'b1;
                        end else if (cmd_stop) begin
                            pend[CI_STOP] <= 1'b1;
                            seq     <= SQ_COND;
                            eng_go  <= 1'b1;
                            eng_op  <= OP_STOP;
                            eng_bit <= 1'b1;
                        end else if (cmd_rxen) begin
                            pend[CI_RX] <= 1'b1;
                            seq     <= SQ_RX;
                            bitcnt  <= '0;
                            eng_go  <= 1'b1;
                            eng_op  <= OP_BIT;
                            eng_bit <= 1'b1;
                        end else if (cmd_ack) begin
                            pend[CI_ACK] <= 1'b1;
                            seq     <= SQ_ACK;
                            eng_go  <= 1'b1;
                            eng_op  <= OP_BIT;
                            eng_bit <= ack_value;
                        end else if (buf_wr) begin
                            buf_rdata <= buf_wdata;
                            shreg     <= buf_wdata;
                            bitcnt    <= '0;
                            seq       <= SQ_TX;
                            eng_go    <= 1'b1;
                            eng_op    <= OP_BIT;
                            eng_bit   <= buf_wdata[BYTE_W-1];
                        end
                    end
                end
                SQ_COND: begin
                    if (eng_done) begin
                        owned     <= !pend[CI_STOP];
                        pend      <= '0;
                        seq       <= SQ_IDLE;
                        done_flag <= 1'b1;
                    end
                end
                SQ_TX: begin
                    if (eng_done) begin
                        if (bitcnt == ACK_SLOT) begin
                            ack_status <= eng_rx_bit;
                            pend       <= '0;
                            seq        <= SQ_IDLE;
                            done_flag  <= 1'b1;
                        end else begin
                            bitcnt  <= bitcnt + 1'b1;
                            eng_go  <= 1'b1;
                            eng_op  <= OP_BIT;
                            eng_bit <= (bitcnt == LAST_DATA) ? 1'b1 : shreg[BYTE_W-2];
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                SQ_RX: begin
                    if (eng_done) begin
                        shreg <= {shreg[BYTE_W-2:0], eng_rx_bit};
                        if (bitcnt == LAST_DATA) begin
                            buf_rdata <= {shreg[BYTE_W-2:0], eng_rx_bit};
                            pend      <= '0;
                            seq       <= SQ_IDLE;
                            done_flag <= 1'b1;
                        end else begin
                            bitcnt  <= bitcnt + 1'b1;
                            eng_go  <= 1'b1;
                            eng_op  <= OP_BIT;
                            eng_bit <= 1'b1;
                        end
                    end
                end
                SQ_ACK: begin
                    if (eng_done) begin
                        pend      <= '0;
                        seq       <= SQ_IDLE;
                        done_flag <= 1'b1;
                    end
                end
                default: seq <= SQ_IDLE;
            endcase
        end
    end

    // R9
    wcol_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && (seq != SQ_IDLE || !owned)) |=> wcol);

    // R13
    cmd_accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend != '0) |-> ($past(seq) == SQ_IDLE));

    // R6
    ack_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_status) |-> ($past(seq) == SQ_TX));

    // R12
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(seq) != SQ_IDLE && seq == SQ_IDLE));

endmodule

// File: rtl/i2c_cmd_master.sv
// Module: top of the command-driven I2C master sequencer.
// Connects the quarter tick generator, the bus operation engine and the
// command sequencer. Lines are open-drain: an *_oe of 1 pulls low.
// Assumes reload changes only while no operation is running.
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int RLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RLD_W-1:0]  reload,
    input  logic              cmd_start,
    input  logic              cmd_rstart,
    input  logic              cmd_stop,
    input  logic              cmd_rxen,
    input  logic              cmd_ack,
    input  logic              ack_value,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              done_clr,
    input  logic              wcol_clr,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              start_pend,
    output logic              rstart_pend,
    output logic              stop_pend,
    output logic              rxen_pend,
    output logic              ack_pend,
    output logic [BYTE_W-1:0] buf_rdata,
    output logic              done_flag,
    output logic              ack_status,
    output logic              wcol,
    output logic              bus_held,
    output logic              tx_busy
);

    logic             tick;
    logic             eng_run;
    logic             eng_done;
    logic             eng_rx_bit;
    logic             eng_go;
    bus_op_e          eng_op;
    logic             eng_bit;
    logic [CMD_N-1:0] pend;

    i2c_qtick #(.RLD_W(RLD_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (eng_run),
        .reload (reload),
        .tick   (tick)
    );

    i2c_bit_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (eng_go),
        .op_in   (eng_op),
        .bit_in  (eng_bit),
        .tick    (tick),
        .sda_in  (sda_in),
        .active  (eng_run),
        .done    (eng_done),
        .rx_bit  (eng_rx_bit),
        .scl_low (scl_oe),
        .sda_low (sda_oe)
    );

    i2c_seq_ctrl u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_rstart (cmd_rstart),
        .cmd_stop   (cmd_stop),
        .cmd_rxen   (cmd_rxen),
        .cmd_ack    (cmd_ack),
        .ack_value  (ack_value),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .done_clr   (done_clr),
        .wcol_clr   (wcol_clr),
        .eng_done   (eng_done),
        .eng_rx_bit (eng_rx_bit),
        .eng_go     (eng_go),
        .eng_op     (eng_op),
        .eng_bit    (eng_bit),
        .pend       (pend),
        .buf_rdata  (buf_rdata),
        .done_flag  (done_flag),
        .ack_status (ack_status),
        .wcol       (wcol),
        .owned      (bus_held),
        .tx_busy    (tx_busy)
    );

    assign start_pend  = pend[CI_START];
    assign rstart_pend = pend[CI_RSTRT];
    assign stop_pend   = pend[CI_STOP];
    assign rxen_pend   = pend[CI_RX];
    assign ack_pend    = pend[CI_ACK];

    // R2
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_pend) |-> (scl_oe && sda_oe));

    // R4
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_pend) |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/i2c_cmd_master_tb.sv
// Bench: sweeps reload 0..3. For each value it runs a full transaction
// (start, address write with ACK, data write with NACK, repeated start,
// read, master acknowledge, stop) against a slave model on the bus and
// checks every result against values computed here.
module i2c_cmd_master_tb;

    localparam int RW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [RW-1:0] reload = '0;
    logic c_start = 0, c_rstart = 0, c_stop = 0, c_rx = 0, c_ack = 0;
    logic ack_value = 0, buf_wr = 0, done_clr = 0, wcol_clr = 0;
    logic [7:0] wdata = '0;

    logic scl_oe, sda_oe, start_pend, rstart_pend, stop_pend, rxen_pend, ack_pend;
    logic done_flag, ack_status, wcol, bus_held, tx_busy;
    logic [7:0] buf_rdata;

    logic s_drv = 1'b0;
    logic sda, scl;
    assign sda = !(sda_oe || s_drv);
    assign scl = !scl_oe;

    i2c_cmd_master #(.RLD_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reload(reload),
        .cmd_start(c_start), .cmd_rstart(c_rstart), .cmd_stop(c_stop),
        .cmd_rxen(c_rx), .cmd_ack(c_ack), .ack_value(ack_value),
        .buf_wr(buf_wr), .buf_wdata(wdata), .done_clr(done_clr), .wcol_clr(wcol_clr),
        .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .start_pend(start_pend), .rstart_pend(rstart_pend), .stop_pend(stop_pend),
        .rxen_pend(rxen_pend), .ack_pend(ack_pend), .buf_rdata(buf_rdata),
        .done_flag(done_flag), .ack_status(ack_status), .wcol(wcol),
        .bus_held(bus_held), .tx_busy(tx_busy)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            report();
        end
    end

    // Slave and bus monitor.
    logic [1:0] s_mode = 2'd2;   // 0 receive+ack, 1 send byte, 2 listen
    logic [7:0] s_tx   = '0;
    logic       s_ack  = 1'b0;
    logic       s_rst  = 1'b0;
    int         s_cnt  = 0;
    logic [8:0] s_sh   = '0;
    logic       scl_p  = 1'b1;
    logic       sda_p  = 1'b1;
    int n_start = 0, n_stop = 0, n_rise = 0, hcnt = 0, last_high = 0;

    always @(posedge clk) begin
        scl_p <= scl;
        sda_p <= sda;
        if (scl === 1'b1 && scl_p && sda_p && sda === 1'b0) n_start <= n_start + 1;
        if (scl === 1'b1 && scl_p && !sda_p && sda === 1'b1) n_stop <= n_stop + 1;
        if (scl === 1'b1 && !scl_p) begin
            hcnt   <= 1;
            s_sh   <= {s_sh[7:0], sda};
            s_cnt  <= s_cnt + 1;
            n_rise <= n_rise + 1;
        end else if (scl === 1'b1) begin
            hcnt <= hcnt + 1;
        end
        if (scl === 1'b0 && scl_p) last_high <= hcnt;
        if (s_rst) begin
            s_cnt <= 0;
            s_drv <= (s_mode == 2'd1) ? ~s_tx[7] : 1'b0;
        end else if (scl === 1'b0 && scl_p) begin
            case (s_mode)
                2'd0:    s_drv <= (s_cnt == 8) ? s_ack : 1'b0;
                2'd1:    s_drv <= (s_cnt < 8) ? ~s_tx[7 - s_cnt] : 1'b0;
                default: s_drv <= 1'b0;
            endcase
        end
    end

    task automatic slave_set(input logic [1:0] m, input logic [7:0] b, input logic a);
        @(negedge clk);
        s_mode = m; s_tx = b; s_ack = a; s_rst = 1'b1;
        @(negedge clk);
        s_rst = 1'b0;
    endtask

    // k: 0 start, 1 rstart, 2 stop, 3 rx, 4 ack, 5 done_clr, 6 wcol_clr
    task automatic cmd(input int k);
        @(negedge clk);
        case (k)
            0: c_start  = 1'b1;
            1: c_rstart = 1'b1;
            2: c_stop   = 1'b1;
            3: c_rx     = 1'b1;
            4: c_ack    = 1'b1;
            5: done_clr = 1'b1;
            default: wcol_clr = 1'b1;
        endcase
        @(negedge clk);
        c_start = 0; c_rstart = 0; c_stop = 0; c_rx = 0; c_ack = 0;
        done_clr = 0; wcol_clr = 0;
    endtask

    task automatic write_buf(input logic [7:0] d);
        @(negedge clk);
        buf_wr = 1'b1; wdata = d;
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done_flag && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, done_flag, 1'b1);
    endtask

    int   n0;
    logic [7:0] addr, dat, rbyte;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 pend", {start_pend, rstart_pend, stop_pend, rxen_pend, ack_pend}, 0);
        chk("R1 flags", {done_flag, wcol, ack_status, bus_held}, 0);

        for (int r = 0; r < 4; r++) begin
            reload = RW'(r);
            addr  = {7'h50 + 7'(r), 1'b0};
            dat   = 8'h3C ^ 8'(r * 69);
            rbyte = 8'hA5 ^ 8'(r * 27);

            // R2 start
            n0 = n_start;
            cmd(0);
            wait_done("R2 done");
            chk("R2 start edge", n_start, n0 + 1);
            chk("R2 lines low", {scl_oe, sda_oe}, 2'b11);
            chk("R2 start_pend", start_pend, 0);
            chk("R2 bus_held", bus_held, 1);
            cmd(5);
            chk("R12 done cleared", done_flag, 0);

            // R13 start while held is ignored
            cmd(0);
            chk("R13 start ignored", start_pend, 0);

            // R5 R6 address write with ACK, plus collision and stray stop
            slave_set(2'd0, 8'h00, 1'b1);
            write_buf(addr);
            chk("R5 tx_busy", tx_busy, 1);
            write_buf(~addr);
            chk("R9 wcol busy", wcol, 1);
            cmd(2);
            chk("R13 stop ignored", stop_pend, 0);
            wait_done("R5 done");
            chk("R5 addr bits", s_sh[8:1], addr);
            chk("R6 ack", ack_status, 0);
            chk("R9 buf kept", buf_rdata, addr);
            chk("R10 high time", last_high, 2 * (r + 1));
            chk("R13 no start", n_start, n0 + 1);
            cmd(6);
            chk("R9 wcol cleared", wcol, 0);
            cmd(5);

            // R5 R6 data write with NACK
            slave_set(2'd0, 8'h00, 1'b0);
            write_buf(dat);
            wait_done("R5 done2");
            chk("R5 data bits", s_sh[8:1], dat);
            chk("R6 nack", ack_status, 1);
            cmd(5);

            // R3 repeated start
            n0 = n_start;
            cmd(1);
            wait_done("R3 done");
            chk("R3 start edge", n_start, n0 + 1);
            chk("R3 rstart_pend", rstart_pend, 0);
            chk("R3 lines low", {scl_oe, sda_oe}, 2'b11);
            cmd(5);

            // R7 receive
            slave_set(2'd1, rbyte, 1'b0);
            cmd(3);
            wait_done("R7 done");
            chk("R7 rx byte", buf_rdata, rbyte);
            chk("R7 line bits", s_sh[7:0], rbyte);
            chk("R7 rxen_pend", rxen_pend, 0);
            chk("R10 rx high", last_high, 2 * (r + 1));
            cmd(5);

            // R8 acknowledge value
            ack_value = r[0];
            slave_set(2'd2, 8'h00, 1'b0);
            cmd(4);
            wait_done("R8 done");
            chk("R8 ack bit", s_sh[0], r[0]);
            chk("R8 ack_pend", ack_pend, 0);
            cmd(5);

            // R4 stop
            n0 = n_stop;
            cmd(2);
            wait_done("R4 done");
            chk("R4 stop edge", n_stop, n0 + 1);
            chk("R4 released", {scl_oe, sda_oe}, 2'b00);
            chk("R4 bus free", bus_held, 0);
            chk("R4 stop_pend", stop_pend, 0);
            cmd(5);

            // R9 write to a free bus; R13 other commands while free
            n0 = n_rise;
            write_buf(~dat);
            cmd(3);
            chk("R13 rx ignored", rxen_pend, 0);
            repeat (40) @(negedge clk);
            chk("R9 wcol free", wcol, 1);
            chk("R9 no scl", n_rise, n0);
            chk("R9 buf kept free", buf_rdata, rbyte);
            chk("R12 no done", done_flag, 0);
            cmd(6);
        end
        report();
    end

endmodule